// File: doc/BRIEF.md
# Merging Write Buffer with Read-Miss Address Check

This block sits between a write-through data cache and the next memory level. Processor writes arrive as a block address, a block of data and a byte-enable mask. Each write is parked in a small multi-entry queue, so the processor keeps running while memory catches up. A second write to a block that is already queued is folded into that entry. It does not take a new one. The queue drains to memory in arrival order, one transfer for each accepted valid/ready handshake. The processor is stalled only when every entry is occupied and the new write cannot be folded.

A read miss from the cache presents its block address on `rd_valid`/`rd_addr` and holds it until `rd_grant`. The block compares that address against every queued entry. If nothing matches, the read goes to memory ahead of the remaining queued writes. If an entry matches, the queue keeps draining until no matching entry is left, and only then is the read issued. Memory never returns data older than a buffered write.

One three-state sequencer owns the shared memory channel. Only one transfer is offered at a time, and an offered transfer is held until it is accepted.
- **IDLE**: nothing is offered.
- **DRAIN**: the head entry is offered on the write port.
- **READ**: the read miss is offered on the read port.

The sequencer takes a new decision only in IDLE, or when the transfer in flight is accepted. The decision takes the first of these that applies:
- **go_read**: a read is waiting and no live entry matches it.
- **go_drain**: entries remain.
- **go_idle**: otherwise.

Top module: `wrbuf_merge`

## Requirements
- R1: A processor write is accepted in the same cycle, with `cpu_stall` low, whenever fewer than DEPTH entries are live. A write to a new block takes one entry.
- R2: `cpu_stall` is high only when a write is presented, all DEPTH entries are live and the write cannot merge. It stays high until a drain transfer is accepted, and it is low in the following cycle.
- R3: A write whose block matches a live entry that is not in flight replaces only its enabled bytes in that entry. The entry's byte mask becomes the OR of both masks, and no entry is consumed. Byte b occupies data bits [8b+7:8b].
- R4: Entries leave in arrival order, one for each cycle where `mem_wr_valid` and `mem_wr_ready` are both high. An entry is freed only in that cycle, and the data memory receives every accepted write.
- R5: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr`, `mem_wr_data` and `mem_wr_be` hold their values.
- R6: A read miss whose block matches no live entry is issued on the read port as soon as the transfer in flight finishes, before any remaining queued writes.
- R7: A read miss whose block matches a live entry is issued only after every matching entry has been transferred. Memory contents at that block equal the last written values when the read is accepted.
- R8: A write to the block of the entry currently offered on the write port does not merge into it. The write takes a fresh entry, so the block is transferred twice.
- R9: The write and read ports are never offered together. An offered read holds `mem_rd_valid` and `mem_rd_addr` until `mem_rd_ready`, and `rd_grant` pulses in the cycle it is accepted.
- R10: After reset the queue is empty and no memory transfer is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_valid | input | 1 | Processor write request |
| cpu_wr_addr | input | AW | Block address of the write |
| cpu_wr_data | input | 8*NBYTES | Write data, byte b at bits [8b+7:8b] |
| cpu_wr_be | input | NBYTES | Byte enables of the write |
| cpu_stall | output | 1 | Write not accepted this cycle |
| rd_valid | input | 1 | Read miss waiting, held until granted |
| rd_addr | input | AW | Block address of the read miss |
| rd_grant | output | 1 | Read miss accepted by memory this cycle |
| mem_wr_valid | output | 1 | Drain transfer offered |
| mem_wr_ready | input | 1 | Memory accepts the drain transfer |
| mem_wr_addr | output | AW | Block address being drained |
| mem_wr_data | output | 8*NBYTES | Data being drained |
| mem_wr_be | output | NBYTES | Byte mask being drained |
| mem_rd_valid | output | 1 | Read miss offered to memory |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | AW | Block address of the read |

## Verification
The bench builds the block with DEPTH=4, AW=4 and NBYTES=4. With these values the queue fills after four writes, which makes the full-queue stall and its release cheap to reach. Every one of the sixteen block addresses is swept as a read-miss target against a fixed set of three queued blocks. For each target the bench computes arithmetically how many drains must come before the read, and checks memory for stale bytes at the moment the read is accepted. Byte-level merging, the refusal to merge into the head in flight, and the held read handshake are covered by directed sequences. A final sweep compares all sixteen blocks of the memory model against the bench's own record of what was written.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
    // Who owns the memory channel this cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_READ  = 2'd2
    } chan_st_e;
endpackage

// File: rtl/wrbuf_cam.sv
module wrbuf_cam #(
    parameter int DEPTH = 4,
    parameter int AW    = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]             key,
    input  logic [DEPTH-1:0]          live,
    input  logic [DEPTH-1:0]          skip,
    input  logic [DEPTH-1:0][AW-1:0]  tags,
    output logic                      hit,
    output logic [IW-1:0]             idx
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = live[g] && !skip[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/wrbuf_seq.sv
module wrbuf_seq
    import wrbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic rd_clash,
    input  logic pending,
    input  logic wr_ready,
    input  logic rd_ready_mem,
    output chan_st_e st,
    output logic wr_offer,
    output logic rd_offer,
    output logic pop,
    output logic rd_done
);
    chan_st_e nxt;
    logic     finish;
    logic     rd_want;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        finish  = (st == ST_IDLE) || (st == ST_DRAIN && wr_ready) || (st == ST_READ && rd_ready_mem);
        rd_want = rd_req && (st != ST_READ);
        nxt     = st;
        if (finish) begin
            if (rd_want && !rd_clash) nxt = ST_READ;    // go_read
            else if (pending)         nxt = ST_DRAIN;   // go_drain
            else                      nxt = ST_IDLE;    // go_idle
        end
    end

    always_comb begin
        wr_offer = 1'b0;
        rd_offer = 1'b0;
        pop      = 1'b0;
        rd_done  = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_DRAIN: begin
                wr_offer = 1'b1;
                pop      = wr_ready;
            end
            ST_READ: begin
                rd_offer = 1'b1;
                rd_done  = rd_ready_mem;
            end
            default:  ;
        endcase
    end

    // R9: one offer at a time, read held until taken
    p_one_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_offer && rd_offer));
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_offer && !rd_ready_mem |=> rd_offer);
endmodule

// File: rtl/wrbuf_merge.sv
module wrbuf_merge
    import wrbuf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int AW     = 4,
    parameter int NBYTES = 4,
    localparam int DW    = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_valid,
    input  logic [AW-1:0]     cpu_wr_addr,
    input  logic [DW-1:0]     cpu_wr_data,
    input  logic [NBYTES-1:0] cpu_wr_be,
    output logic              cpu_stall,
    input  logic              rd_valid,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_grant,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [DW-1:0]     mem_wr_data,
    output logic [NBYTES-1:0] mem_wr_be,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [AW-1:0]     mem_rd_addr
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][AW-1:0]     tags;
    logic [DEPTH-1:0][DW-1:0]     dat;
    logic [DEPTH-1:0][NBYTES-1:0] ben;
    logic [DEPTH-1:0]             live;
    logic [IW-1:0]                head, tail;
    logic [CW-1:0]                count, count_nxt;

    chan_st_e         st;
    logic             wr_offer, rd_offer, pop, rd_done;
    logic [DEPTH-1:0] head_oh, m_skip, r_skip;
    logic             m_hit, r_hit, full, wr_take, do_merge, do_alloc, rd_clash, pending;
    logic [IW-1:0]    m_idx, r_idx;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_oh = DEPTH'(1) << head;
    assign m_skip  = (st == ST_DRAIN) ? head_oh : '0;   // never touch the entry in flight
    assign r_skip  = pop ? head_oh : '0;                // leaving this cycle

    wrbuf_cam #(.DEPTH(DEPTH), .AW(AW)) u_merge_cam (
        .key(cpu_wr_addr), .live(live), .skip(m_skip), .tags(tags), .hit(m_hit), .idx(m_idx)
    );

    wrbuf_cam #(.DEPTH(DEPTH), .AW(AW)) u_read_cam (
        .key(rd_addr), .live(live), .skip(r_skip), .tags(tags), .hit(r_hit), .idx(r_idx)
    );

    assign full      = (count == CW'(DEPTH));
    assign cpu_stall = cpu_wr_valid && !m_hit && full;
    assign wr_take   = cpu_wr_valid && !cpu_stall;
    assign do_merge  = wr_take && m_hit;
    assign do_alloc  = wr_take && !m_hit;
    assign rd_clash  = r_hit || (wr_take && (cpu_wr_addr == rd_addr));
    assign count_nxt = count + CW'(do_alloc) - CW'(pop);
    assign pending   = (count_nxt != '0);

    wrbuf_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_valid), .rd_clash(rd_clash), .pending(pending),
        .wr_ready(mem_wr_ready), .rd_ready_mem(mem_rd_ready), .st(st),
        .wr_offer(wr_offer), .rd_offer(rd_offer), .pop(pop), .rd_done(rd_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            count <= count_nxt;
            if (do_alloc) begin
                live[tail] <= 1'b1;
                tail       <= bump(tail);
            end
            if (pop) begin
                live[head] <= 1'b0;
                head       <= bump(head);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_alloc) begin
            tags[tail] <= cpu_wr_addr;
            dat[tail]  <= cpu_wr_data;
            ben[tail]  <= cpu_wr_be;
        end
        if (do_merge) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (cpu_wr_be[b]) dat[m_idx][8*b +: 8] <= cpu_wr_data[8*b +: 8];
            end
            ben[m_idx] <= ben[m_idx] | cpu_wr_be;
        end
    end

    assign mem_wr_valid = wr_offer;
    assign mem_wr_addr  = tags[head];
    assign mem_wr_data  = dat[head];
    assign mem_wr_be    = ben[head];
    assign mem_rd_valid = rd_offer;
    assign mem_rd_addr  = rd_addr;
    assign rd_grant     = rd_done;

    p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (count == CW'(DEPTH)));
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall && !(mem_wr_valid && mem_wr_ready) |=> (count == CW'(DEPTH)));
    p_merge_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take && m_hit && !pop |=> (count == $past(count)));
    p_free_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_valid && mem_wr_ready) |=> (count >= $past(count)));
    p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
            && $stable(mem_wr_data) && $stable(mem_wr_be));
    p_rd_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_valid) |-> !r_hit);
endmodule

// File: tb/wrbuf_merge_bench.sv
module wrbuf_merge_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int DW = 8 * NB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_wr_valid = 1'b0;
    logic [AW-1:0] cpu_wr_addr = '0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic [NB-1:0] cpu_wr_be = '0;
    logic rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic mem_wr_ready = 1'b0;
    logic mem_rd_ready = 1'b1;
    logic cpu_stall, rd_grant, mem_wr_valid, mem_rd_valid;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data;
    logic [NB-1:0] mem_wr_be;

    wrbuf_merge #(.DEPTH(DEPTH), .AW(AW), .NBYTES(NB)) u_wrbuf_merge (
        .clk(clk), .rst_n(rst_n), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr),
        .cpu_wr_data(cpu_wr_data), .cpu_wr_be(cpu_wr_be), .cpu_stall(cpu_stall),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_grant(rd_grant),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr)
    );

    always #(CLK_P/2) clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] gold [16][NB];
    logic [7:0] memm [16][NB];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    logic [NB-1:0] log_be [64];
    int nlog = 0;
    bit rd_seen = 0;
    int rd_nlog = 0;
    bit stale = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // Sample handshakes just after the falling edge, then wait one cycle.
    task automatic tick();
        #1;
        if (mem_rd_valid && mem_rd_ready) begin
            rd_seen = 1;
            rd_nlog = nlog;
            for (int b = 0; b < NB; b++) if (memm[mem_rd_addr][b] != gold[mem_rd_addr][b]) stale = 1;
        end
        if (mem_wr_valid && mem_wr_ready) begin
            log_addr[nlog] = mem_wr_addr;
            log_data[nlog] = mem_wr_data;
            log_be[nlog] = mem_wr_be;
            nlog++;
            for (int b = 0; b < NB; b++) if (mem_wr_be[b]) memm[mem_wr_addr][b] = mem_wr_data[8*b +: 8];
        end
        if (cpu_wr_valid && !cpu_stall)
            for (int b = 0; b < NB; b++) if (cpu_wr_be[b]) gold[cpu_wr_addr][b] = cpu_wr_data[8*b +: 8];
        @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be,
                          input string req);
        cpu_wr_valid = 1; cpu_wr_addr = a; cpu_wr_data = d; cpu_wr_be = be;
        #1 chk(cpu_stall == 0, req, cpu_stall, 0);
        tick();
        cpu_wr_valid = 0;
    endtask

    task automatic drain_all();
        mem_wr_ready = 1;
        repeat (12) tick();
        mem_wr_ready = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        nfail++; nchk++;
        $display("FAIL R4 watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        for (int i = 0; i < 16; i++) for (int b = 0; b < NB; b++) begin gold[i][b] = 0; memm[i][b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(mem_wr_valid == 0, "R10 wr idle", mem_wr_valid, 0);
        chk(mem_rd_valid == 0, "R10 rd idle", mem_rd_valid, 0);
        chk(rd_grant == 0 && cpu_stall == 0, "R10 grant/stall", {rd_grant, cpu_stall}, 0);
        @(negedge clk);

        // R1/R4/R5: three blocks queued, held, then drained in order
        nlog = 0;
        cpu_wr(1, 32'h01010101, 4'hF, "R1 write a");
        cpu_wr(2, 32'h02020202, 4'hF, "R1 write b");
        cpu_wr(3, 32'h03030303, 4'hF, "R1 write c");
        for (int k = 0; k < 3; k++) begin
            #1 chk(mem_wr_valid == 1 && mem_wr_addr == 1, "R5 hold head", mem_wr_addr, 1);
            tick();
        end
        drain_all();
        chk(nlog == 3, "R4 drain count", nlog, 3);
        for (int k = 0; k < 3; k++) chk(log_addr[k] == AW'(k + 1), "R4 order", log_addr[k], k + 1);

        // R2: fill, stall, release after one accepted drain
        nlog = 0;
        for (int k = 4; k < 8; k++) cpu_wr(AW'(k), DW'(k * 32'h11), 4'hF, "R1 fill");
        cpu_wr_valid = 1; cpu_wr_addr = 8; cpu_wr_data = 32'h88; cpu_wr_be = 4'hF;
        for (int k = 0; k < 3; k++) begin
            #1 chk(cpu_stall == 1, "R2 stall when full", cpu_stall, 1);
            tick();
        end
        mem_wr_ready = 1;
        #1 chk(cpu_stall == 1, "R2 stall in drain cycle", cpu_stall, 1);
        tick();
        mem_wr_ready = 0;
        #1 chk(cpu_stall == 0, "R2 release", cpu_stall, 0);
        tick();
        cpu_wr_valid = 0;
        drain_all();
        chk(nlog == 5, "R4 count after stall", nlog, 5);
        for (int k = 0; k < 5; k++) chk(log_addr[k] == AW'(k + 4), "R4 order after stall", log_addr[k], k + 4);

        // R3: merge into a queued, not-in-flight entry
        nlog = 0;
        cpu_wr(5, 32'h11223344, 4'b0011, "R1 merge setup");
        cpu_wr(6, 32'h55667788, 4'b0011, "R1 merge setup");
        cpu_wr(6, 32'hAABBCCDD, 4'b0110, "R3 merge write");
        cpu_wr(9, 32'h9, 4'hF, "R3 room left 1");
        cpu_wr(10, 32'hA, 4'hF, "R3 room left 2");
        cpu_wr_valid = 1; cpu_wr_addr = 11; cpu_wr_be = 4'hF;
        #1 chk(cpu_stall == 1, "R3 merge took no entry", cpu_stall, 1);
        cpu_wr_valid = 0;
        @(negedge clk);
        drain_all();
        chk(nlog == 4, "R3 transfers", nlog, 4);
        chk(log_addr[1] == 6 && log_be[1] == 4'b0111, "R3 mask", {log_addr[1], log_be[1]}, {4'd6, 4'b0111});
        chk((log_data[1] & 32'h00FFFFFF) == 32'h00BBCC88, "R3 bytes", log_data[1] & 32'h00FFFFFF, 32'h00BBCC88);

        // R8: same block as entry in flight allocates fresh
        nlog = 0;
        cpu_wr(9, 32'h00000001, 4'b0001, "R8 first");
        cpu_wr(9, 32'h00000200, 4'b0010, "R8 second");
        drain_all();
        chk(nlog == 2, "R8 two transfers", nlog, 2);
        chk(log_be[0] == 4'b0001 && log_be[1] == 4'b0010, "R8 masks", {log_be[0], log_be[1]}, 8'h12);

        // R6/R7: sweep every read-miss block against queued {3,7,12}
        for (int a = 0; a < 16; a++) begin
            int exp_n;
            nlog = 0; rd_seen = 0; stale = 0;
            cpu_wr(3, DW'(a + 32'h300), 4'hF, "R1 sweep");
            cpu_wr(7, DW'(a + 32'h700), 4'hF, "R1 sweep");
            cpu_wr(12, DW'(a + 32'hC00), 4'hF, "R1 sweep");
            rd_addr = AW'(a); rd_valid = 1; mem_wr_ready = 1;
            for (int t = 0; t < 20 && !rd_seen; t++) tick();
            rd_valid = 0;
            exp_n = (a == 7) ? 2 : (a == 12) ? 3 : 1;
            chk(rd_seen && rd_nlog == exp_n, (exp_n == 1 && a != 3) ? "R6 read ahead" : "R7 drain first",
                rd_nlog, exp_n);
            chk(stale == 0, "R7 no stale data", stale, 0);
            drain_all();
        end

        // R9: held read offer excludes the write port
        nlog = 0; mem_rd_ready = 0;
        cpu_wr(2, 32'h2222, 4'hF, "R1 r9 setup");
        cpu_wr(13, 32'hDDDD, 4'hF, "R1 r9 setup");
        rd_addr = 14; rd_valid = 1; mem_wr_ready = 1;
        tick();
        mem_wr_ready = 0;
        for (int k = 0; k < 3; k++) begin
            #1 chk(mem_rd_valid && !mem_wr_valid && !rd_grant && mem_rd_addr == 14, "R9 read held",
                   {mem_rd_valid, mem_wr_valid, rd_grant}, 3'b100);
            tick();
        end
        mem_rd_ready = 1;
        #1 chk(rd_grant == 1, "R9 grant pulse", rd_grant, 1);
        tick();
        rd_valid = 0;
        #1 chk(rd_grant == 0, "R9 grant single", rd_grant, 0);
        drain_all();

        for (int i = 0; i < 16; i++) begin
            bit same = 1;
            for (int b = 0; b < NB; b++) if (memm[i][b] != gold[i][b]) same = 0;
            chk(same, "R4 memory image", i, i);
        end
        report();
    end
endmodule